// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block sits between two parallel data buses, called A and B, and moves data between them in either direction. Each direction has a storage register with its own capture strobe. For each direction a select input decides what goes onto the far bus: the live value from the near bus pins, or the copy held in the register. Every bus pin is split into an input vector, an output vector and an output-enable vector, so the block can sit behind ordinary tri-state pad cells.

The elaboration parameter `DUAL_EN` picks one of two control styles. In the single-enable style (`DUAL_EN = 0`), one active-low transfer enable and one direction input decide which bus, if any, is driven. In the dual-enable style (`DUAL_EN = 1`), an active-high B-side enable and an active-low A-side enable act independently, so both buses can be driven at once. Both styles decode to one internal drive mode with four named values: `DRV_NONE` (both buses isolated), `DRV_A_ONLY`, `DRV_B_ONLY` and `DRV_BOTH`. The decode is combinational, so the mode is re-evaluated every cycle with no transitions of its own. Each register captures the resolved value of its own bus. A bus that is being driven therefore stores the value driven onto it, which lets one register be copied into the other.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both registers to zero at the clock edge where it is sampled high.
- R2: At a rising `clk` edge with `a_cap` high, the A-side register loads the resolved A bus: `a_out` when `a_oe` is all ones, `a_in` otherwise. With `a_cap` low, the register holds its value.
- R3: At a rising `clk` edge with `b_cap` high, the B-side register loads the resolved B bus: `b_out` when `b_oe` is all ones, `b_in` otherwise. With `b_cap` low, the register holds its value.
- R4: A capture takes place whatever the output-enable state, including when both buses are isolated.
- R5: When the B bus is driven, `b_out` equals `a_in` if `b_use_stored` is 0, and equals the A-side register if `b_use_stored` is 1.
- R6: When the A bus is driven, `a_out` equals `b_in` if `a_use_stored` is 0, and equals the B-side register if `a_use_stored` is 1.
- R7: With `DUAL_EN = 0`, the drive state is set as follows. `xfer_en_n` = 1 isolates both buses. `xfer_en_n` = 0 with `to_b` = 0 drives only A. `xfer_en_n` = 0 with `to_b` = 1 drives only B. The two buses are never driven together.
- R8: With `DUAL_EN = 1`, `b_drive_en` = 1 drives B and `a_drive_en_n` = 0 drives A, each independently of the other. Both buses may carry stored data at the same time.
- R9: If a bus is driven from the opposite register while its own register captures, the captured value is the driven value. If both registers capture while both buses are driven from stored data, the two values swap.
- R10: The enable inputs of the style not selected by `DUAL_EN` have no effect on any output. Each output-enable vector is either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both registers |
| rst | input | 1 | Synchronous active-high reset |
| a_cap | input | 1 | Capture strobe for the A-side register |
| b_cap | input | 1 | Capture strobe for the B-side register |
| b_use_stored | input | 1 | B bus source: 0 live A pins, 1 A-side register |
| a_use_stored | input | 1 | A bus source: 0 live B pins, 1 B-side register |
| xfer_en_n | input | 1 | Single-enable style: active-low transfer enable |
| to_b | input | 1 | Single-enable style: 1 drives B, 0 drives A |
| b_drive_en | input | 1 | Dual-enable style: active-high B output enable |
| a_drive_en_n | input | 1 | Dual-enable style: active-low A output enable |
| a_in | input | W | A bus pin input |
| a_out | output | W | A bus pin output value |
| a_oe | output | W | A bus pin output enables |
| b_in | input | W | B bus pin input |
| b_out | output | W | B bus pin output value |
| b_oe | output | W | B bus pin output enables |

## Verification
The assertions assume that `rst` is high at the first clock edge and that inputs change only away from the rising edge. They also assume that the live source of a driven bus is the opposite pin input, not the resolved opposite bus. Without that assumption the dual-enable style would close a loop whenever both buses are driven live. The stimulus changes every input on the falling edge and holds it through the next rising edge. After the directed sequence, it applies random values to every input, the strobes and the enables of the unused style included, so that any drive state can meet any capture pattern without breaking these assumptions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        DRV_NONE   = 2'd0,
        DRV_A_ONLY = 2'd1,
        DRV_B_ONLY = 2'd2,
        DRV_BOTH   = 2'd3
    } drv_mode_e;

endpackage

// File: rtl/xcvr_oe_decode.sv
module xcvr_oe_decode
    import xcvr_pkg::*;
#(
    parameter bit DUAL_EN = 1'b0
) (
    input  logic      xfer_en_n,
    input  logic      to_b,
    input  logic      b_drive_en,
    input  logic      a_drive_en_n,
    output drv_mode_e mode
);

    generate
        if (DUAL_EN) begin : g_dual
            always_comb begin
                unique case ({b_drive_en, a_drive_en_n})
                    2'b00:   mode = DRV_A_ONLY;
                    2'b01:   mode = DRV_NONE;
                    2'b10:   mode = DRV_BOTH;
                    default: mode = DRV_B_ONLY;
                endcase
            end
        end else begin : g_single
            always_comb begin
                unique case ({xfer_en_n, to_b})
                    2'b00:   mode = DRV_A_ONLY;
                    2'b01:   mode = DRV_B_ONLY;
                    default: mode = DRV_NONE;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] cap_data,
    input  logic [W-1:0] live_data,
    input  logic         use_stored,
    output logic [W-1:0] drive_data
);

    logic [W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (cap) begin
            store_q <= cap_data;
        end
    end

    always_comb begin
        drive_data = use_stored ? store_q : live_data;
    end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int W       = 8,
    parameter bit DUAL_EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a_cap,
    input  logic         b_cap,
    input  logic         b_use_stored,
    input  logic         a_use_stored,
    input  logic         xfer_en_n,
    input  logic         to_b,
    input  logic         b_drive_en,
    input  logic         a_drive_en_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    drv_mode_e    mode;
    logic         drive_a;
    logic         drive_b;
    logic [W-1:0] a_resolved;
    logic [W-1:0] b_resolved;

    xcvr_oe_decode #(.DUAL_EN(DUAL_EN)) u_decode (
        .xfer_en_n    (xfer_en_n),
        .to_b         (to_b),
        .b_drive_en   (b_drive_en),
        .a_drive_en_n (a_drive_en_n),
        .mode         (mode)
    );

    always_comb begin
        drive_a = 1'b0;
        drive_b = 1'b0;
        unique case (mode)
            DRV_A_ONLY: drive_a = 1'b1;
            DRV_B_ONLY: drive_b = 1'b1;
            DRV_BOTH: begin
                drive_a = 1'b1;
                drive_b = 1'b1;
            end
            default: ;
        endcase
    end

    // Live source is the opposite pin input, so no combinational loop forms.
    always_comb begin
        a_resolved = drive_a ? a_out : a_in;
        b_resolved = drive_b ? b_out : b_in;
    end

    // A-side register feeds the B bus.
    xcvr_lane #(.W(W)) u_lane_ab (
        .clk        (clk),
        .rst        (rst),
        .cap        (a_cap),
        .cap_data   (a_resolved),
        .live_data  (a_in),
        .use_stored (b_use_stored),
        .drive_data (b_out)
    );

    // B-side register feeds the A bus.
    xcvr_lane #(.W(W)) u_lane_ba (
        .clk        (clk),
        .rst        (rst),
        .cap        (b_cap),
        .cap_data   (b_resolved),
        .live_data  (b_in),
        .use_stored (a_use_stored),
        .drive_data (a_out)
    );

    assign a_oe = {W{drive_a}};
    assign b_oe = {W{drive_b}};

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
    parameter int W       = 8,
    parameter bit DUAL_EN = 1'b0
) (
    input logic         clk,
    input logic         rst,
    input logic         a_cap,
    input logic         b_cap,
    input logic         b_use_stored,
    input logic         a_use_stored,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);

    logic [W-1:0] a_seen;
    logic [W-1:0] b_seen;
    assign a_seen = a_oe[0] ? a_out : a_in;
    assign b_seen = b_oe[0] ? b_out : b_in;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!(b_use_stored && b_oe[0]) || b_out == '0));

    // R2
    a_capture_chk: assert property (@(posedge clk) disable iff (rst)
        a_cap |=> (!(b_use_stored && b_oe[0]) || b_out == $past(a_seen)));

    // R2
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!a_cap && b_use_stored && b_oe[0]) |=> (!(b_use_stored && b_oe[0]) || $stable(b_out)));

    // R3
    b_capture_chk: assert property (@(posedge clk) disable iff (rst)
        b_cap |=> (!(a_use_stored && a_oe[0]) || a_out == $past(b_seen)));

    // R5
    b_live_chk: assert property (@(posedge clk) disable iff (rst)
        (b_oe[0] && !b_use_stored) |-> b_out == a_in);

    // R6
    a_live_chk: assert property (@(posedge clk) disable iff (rst)
        (a_oe[0] && !a_use_stored) |-> a_out == b_in);

    // R7
    single_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !DUAL_EN |-> !(a_oe[0] && b_oe[0]));

    // R10
    oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.W(W), .DUAL_EN(DUAL_EN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .a_cap        (a_cap),
    .b_cap        (b_cap),
    .b_use_stored (b_use_stored),
    .a_use_stored (a_use_stored),
    .a_in         (a_in),
    .a_out        (a_out),
    .a_oe         (a_oe),
    .b_in         (b_in),
    .b_out        (b_out),
    .b_oe         (b_oe)
);

// File: tb/tb_dual_reg_xcvr.sv
module tb_dual_reg_xcvr;

    localparam int W = 8;

    typedef struct {
        int           idx;
        logic         exp_da;
        logic         exp_db;
        logic [W-1:0] exp_a;
        logic [W-1:0] exp_b;
        string        tag;
    } item_t;

    logic clk = 1'b0;
    logic rst, a_cap, b_cap, b_use_stored, a_use_stored;
    logic xfer_en_n, to_b, b_drive_en, a_drive_en_n;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out [2];
    logic [W-1:0] a_oe  [2];
    logic [W-1:0] b_out [2];
    logic [W-1:0] b_oe  [2];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    item_t        q[$];
    event         chk_ev;
    logic [W-1:0] m_ab [2];
    logic [W-1:0] m_ba [2];

    always #2.5 clk = ~clk;

    dual_reg_xcvr #(.W(W), .DUAL_EN(1'b0)) dut (
        .clk(clk), .rst(rst), .a_cap(a_cap), .b_cap(b_cap),
        .b_use_stored(b_use_stored), .a_use_stored(a_use_stored),
        .xfer_en_n(xfer_en_n), .to_b(to_b), .b_drive_en(b_drive_en),
        .a_drive_en_n(a_drive_en_n), .a_in(a_in), .a_out(a_out[0]),
        .a_oe(a_oe[0]), .b_in(b_in), .b_out(b_out[0]), .b_oe(b_oe[0])
    );

    dual_reg_xcvr #(.W(W), .DUAL_EN(1'b1)) dut_dual (
        .clk(clk), .rst(rst), .a_cap(a_cap), .b_cap(b_cap),
        .b_use_stored(b_use_stored), .a_use_stored(a_use_stored),
        .xfer_en_n(xfer_en_n), .to_b(to_b), .b_drive_en(b_drive_en),
        .a_drive_en_n(a_drive_en_n), .a_in(a_in), .a_out(a_out[1]),
        .a_oe(a_oe[1]), .b_in(b_in), .b_out(b_out[1]), .b_oe(b_oe[1])
    );

    // Drive enables from R7 (index 0) and R8 (index 1).
    function automatic logic want_a(int i);
        return (i == 0) ? (!xfer_en_n && !to_b) : !a_drive_en_n;
    endfunction

    function automatic logic want_b(int i);
        return (i == 0) ? (!xfer_en_n && to_b) : b_drive_en;
    endfunction

    task automatic step(string tag);
        logic         da [2];
        logic         db [2];
        logic [W-1:0] ea [2];
        logic [W-1:0] eb [2];
        #1;
        for (int i = 0; i < 2; i++) begin
            da[i] = want_a(i);
            db[i] = want_b(i);
            ea[i] = a_use_stored ? m_ba[i] : b_in;
            eb[i] = b_use_stored ? m_ab[i] : a_in;
            q.push_back('{i, da[i], db[i], ea[i], eb[i], tag});
        end
        -> chk_ev;
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                m_ab[i] = '0;
                m_ba[i] = '0;
            end else begin
                if (a_cap) m_ab[i] = da[i] ? ea[i] : a_in;
                if (b_cap) m_ba[i] = db[i] ? eb[i] : b_in;
            end
        end
        @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if ((a_oe[it.idx] !== {W{it.exp_da}}) ||
                    (b_oe[it.idx] !== {W{it.exp_db}}) ||
                    (it.exp_da && a_out[it.idx] !== it.exp_a) ||
                    (it.exp_db && b_out[it.idx] !== it.exp_b)) begin
                    errors++;
                    $display("FAIL %s inst%0d: a_oe=%h a_out=%h b_oe=%h b_out=%h expected a_oe=%b a=%h b_oe=%b b=%h",
                             it.tag, it.idx, a_oe[it.idx], a_out[it.idx], b_oe[it.idx],
                             b_out[it.idx], it.exp_da, it.exp_a, it.exp_db, it.exp_b);
                end
            end
        end
    end

    task automatic isolate();
        xfer_en_n = 1'b1; b_drive_en = 1'b0; a_drive_en_n = 1'b1;
    endtask

    initial begin : driver
        m_ab[0] = 'x; m_ab[1] = 'x; m_ba[0] = 'x; m_ba[1] = 'x;
        rst = 1'b1; a_cap = 0; b_cap = 0; b_use_stored = 0; a_use_stored = 0;
        to_b = 0; a_in = '0; b_in = '0;
        isolate();
        @(negedge clk);
        step("R1");
        // R1: registers read back zero after reset
        rst = 0; xfer_en_n = 0; to_b = 1; b_use_stored = 1; b_drive_en = 1;
        step("R1");
        a_use_stored = 1; to_b = 0; a_drive_en_n = 0; b_drive_en = 0;
        step("R1");
        // R4: capture A while both buses are isolated
        isolate(); a_in = 8'h5A; a_cap = 1;
        step("R4");
        // R2: stored A onto B
        a_cap = 0; a_in = 8'h00; xfer_en_n = 0; to_b = 1; b_use_stored = 1; b_drive_en = 1;
        step("R2");
        a_in = 8'hFF;
        step("R2");
        // R4 / R3: capture B while isolated, then read via A
        isolate(); b_in = 8'hC3; b_cap = 1;
        step("R4");
        b_cap = 0; b_in = 8'h00; xfer_en_n = 0; to_b = 0; a_use_stored = 1; a_drive_en_n = 0;
        step("R3");
        // R6: live B onto A
        a_use_stored = 0; b_in = 8'h3C;
        step("R6");
        // R5: live A onto B
        to_b = 1; b_use_stored = 0; b_drive_en = 1; a_drive_en_n = 1; a_in = 8'h96;
        step("R5");
        // R7 / R10: single style isolated while dual-style enables are active
        xfer_en_n = 1; b_drive_en = 1; a_drive_en_n = 0;
        step("R7");
        to_b = 0;
        step("R10");
        // R8: both buses carry stored data
        xfer_en_n = 0; to_b = 0; b_use_stored = 1; a_use_stored = 1;
        step("R8");
        // R10: dual style isolated while single-style enables say drive
        b_drive_en = 0; a_drive_en_n = 1; xfer_en_n = 0; to_b = 1;
        step("R10");
        // R9: copy B-side register into A-side register through the A bus
        to_b = 0; a_use_stored = 1; a_drive_en_n = 0; a_in = 8'h00; a_cap = 1;
        step("R9");
        a_cap = 0; to_b = 1; b_use_stored = 1; b_drive_en = 1; a_drive_en_n = 1;
        step("R9");
        // R9: load distinct values, then simultaneous swap in dual style
        isolate(); a_in = 8'h12; b_in = 8'h34; a_cap = 1; b_cap = 1;
        step("R2");
        b_drive_en = 1; a_drive_en_n = 0; a_use_stored = 1; b_use_stored = 1;
        step("R9");
        a_cap = 0; b_cap = 0;
        step("R9");
        // R3: simultaneous live capture, both isolated
        isolate(); a_use_stored = 0; b_use_stored = 0; a_in = 8'hA5; b_in = 8'h5A;
        a_cap = 1; b_cap = 1;
        step("R3");
        a_cap = 0; b_cap = 0; a_use_stored = 1; b_use_stored = 1;
        b_drive_en = 1; a_drive_en_n = 0;
        step("R3");
        // R5 / R6 / R9: random traffic over every input
        for (int n = 0; n < 400; n++) begin
            {a_cap, b_cap, b_use_stored, a_use_stored} = 4'($urandom);
            {xfer_en_n, to_b, b_drive_en, a_drive_en_n} = 4'($urandom);
            a_in = W'($urandom);
            b_in = W'($urandom);
            step("R5");
        end
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog all: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule